// File: doc/BRIEF.md
# Synchronous 537-Byte Frame Generator and Aligner

This block carries 530 fixed-rate byte circuits over a link, one byte per circuit per 537-byte frame. The frame repeats every 125 µs at 34.368 Mbit/s. The block moves one byte per clock. A circuit has no label: its slot position after the frame start identifies it, and slot numbering restarts at every frame.

The transmit sequencer walks through the byte positions of the frame and works in two phases. In the overhead phase it emits seven bytes in this order:
- two alignment bytes,
- an even bit-interleaved parity byte computed over the previous frame,
- a trail-trace byte,
- a maintenance byte,
- a network-operator byte,
- a general communication byte.

In the payload phase it requests each of the 530 slots in turn and sends the offered byte, or an idle byte when no byte is offered.

The receive state machine has three states: `RX_HUNT`, `RX_CONFIRM` and `RX_LOCKED`. It starts in `RX_HUNT` and searches every byte boundary for the alignment pair.
- `RX_HUNT` → `RX_CONFIRM`: the pair is seen.
- `RX_CONFIRM` → `RX_LOCKED`: the pair is seen again at the expected spacing until three hits in a row have been counted.
- `RX_CONFIRM` → `RX_HUNT`: one miss.
- `RX_LOCKED` → `RX_HUNT`: four misses in a row.

While locked, the receiver delivers payload bytes tagged with their slot number and checks each parity byte. A parity mismatch is counted and is reported back in the next transmitted maintenance byte.

Top module: `sframe_top`

## Requirements
- R1: A frame is 537 bytes, one per clock. `tx_sof` is high for exactly the byte at frame position 0. Position 0 carries FA1 (default 8'hF6) and position 1 carries FA2 (default 8'h28).
- R2: Positions 3, 5 and 6 carry `tx_trace`, `tx_netop` and `tx_gcc`.
- R3: During frame positions 7 to 536, `tx_slot_req` is high and `tx_slot_num` equals the position minus 7 (0 to 529). The slot number restarts at 0 in each frame. A byte offered with `tx_slot_valid` is sent on `tx_byte` in the following cycle.
- R4: If `tx_slot_valid` is low when a slot is requested, the byte sent for that slot is the idle value 8'hFF.
- R5: Position 2 carries the bitwise XOR (even parity per bit) of all 537 bytes of the previous frame. It is 8'h00 in the first frame after reset.
- R6: The maintenance byte at position 4 is laid out as follows: bit 7 is the receive-fail flag (1 when the receiver is not locked), bit 6 is the far-end block error flag, bits 5:3 are zero, and bits 2:0 are `tx_ptype`.
- R7: The receiver asserts `rx_lock` only after the alignment pair has appeared at the 537-byte spacing in 3 consecutive frames. It leaves `RX_CONFIRM` for `RX_HUNT` on a single miss.
- R8: Once locked, the receiver stays locked through 3 consecutive alignment misses. It drops `rx_lock` on the 4th consecutive miss.
- R9: While locked, the receiver outputs each payload byte on `rx_pay_data` with `rx_pay_valid` high and `rx_pay_slot` equal to its slot number. Slot numbers count 0 to 529 in order within each frame.
- R10: While locked, a received parity byte that differs from the XOR of the previous received frame adds 1 to `rx_bip_errs`. The counter is 16 bits and saturates at its maximum. Mismatches outside lock are not counted.
- R11: A parity mismatch sets bit 6 of the next transmitted maintenance byte. It sets that bit in that one byte only.
- R12: During reset, `tx_sof`, `rx_lock` and `rx_pay_valid` are low and `rx_bip_errs` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_trace | input | 8 | Trail-trace byte to send |
| tx_netop | input | 8 | Network-operator byte to send |
| tx_gcc | input | 8 | General communication byte to send |
| tx_ptype | input | 3 | Payload type field of the maintenance byte |
| tx_slot_req | output | 1 | A payload slot is due this cycle |
| tx_slot_num | output | 10 | Number of the slot being requested |
| tx_slot_valid | input | 1 | A byte is offered for the requested slot |
| tx_slot_data | input | 8 | Offered payload byte |
| tx_byte | output | 8 | Transmitted byte stream |
| tx_sof | output | 1 | Marks frame position 0 on `tx_byte` |
| rx_byte | input | 8 | Received byte stream |
| rx_lock | output | 1 | Receiver is in `RX_LOCKED` |
| rx_pay_valid | output | 1 | A received payload byte is presented |
| rx_pay_slot | output | 10 | Slot number of the presented byte |
| rx_pay_data | output | 8 | Received payload byte |
| rx_bip_errs | output | 16 | Saturating count of parity mismatches |

## Verification
Some behaviour is checked by assertions on every cycle:
- that `tx_sof` coincides with the first alignment byte;
- that an offered or missing slot byte becomes the data or idle value one cycle later;
- that the slot number stays in range;
- that the error counter only steps by one and holds at saturation;
- that `rx_lock` is entered only from `RX_CONFIRM`;
- that payload is never presented outside lock.

The bench's scenarios show the rest by looping the transmit stream into the receiver and corrupting chosen bytes:
- frame length and parity contents;
- the three-frame lock delay;
- the tolerance of three missed alignment pairs and loss of lock on the fourth;
- a single far-end block error report;
- relock after loss.

// File: rtl/sframe_pkg.sv
package sframe_pkg;
    localparam int NUM_OH = 7;

    typedef enum logic [2:0] {
        OH_FA1   = 3'd0,
        OH_FA2   = 3'd1,
        OH_BIP   = 3'd2,
        OH_TRACE = 3'd3,
        OH_MAINT = 3'd4,
        OH_NETOP = 3'd5,
        OH_GCC   = 3'd6
    } oh_idx_t;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_CONFIRM,
        RX_LOCKED
    } rx_state_t;
endpackage

// File: rtl/sframe_tx.sv
module sframe_tx
    import sframe_pkg::*;
#(
    parameter int         PAY_LEN = 530,
    parameter logic [7:0] FA1     = 8'hF6,
    parameter logic [7:0] FA2     = 8'h28,
    parameter logic [7:0] IDLE    = 8'hFF,
    localparam int FRAME_LEN = NUM_OH + PAY_LEN,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int SLOT_W    = $clog2(PAY_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        trace,
    input  logic [7:0]        netop,
    input  logic [7:0]        gcc,
    input  logic [2:0]        ptype,
    input  logic              far_fail,
    input  logic              blk_err,
    output logic              slot_req,
    output logic [SLOT_W-1:0] slot_num,
    input  logic              slot_valid,
    input  logic [7:0]        slot_data,
    output logic [7:0]        byte_out,
    output logic              sof
);
    logic [POS_W-1:0] pos;
    logic [7:0]       acc;
    logic [7:0]       bip_prev;
    logic [7:0]       nxt;
    logic             febe_pend;
    logic             last;
    oh_idx_t          oh;

    assign last     = (pos == POS_W'(FRAME_LEN - 1));
    assign slot_req = (pos >= POS_W'(NUM_OH));
    assign slot_num = slot_req ? SLOT_W'(pos - POS_W'(NUM_OH)) : '0;
    assign oh       = oh_idx_t'(pos[2:0]);

    always_comb begin
        nxt = IDLE;
        if (slot_req) begin
            nxt = slot_valid ? slot_data : IDLE;
        end else begin
            unique case (oh)
                OH_FA1:   nxt = FA1;
                OH_FA2:   nxt = FA2;
                OH_BIP:   nxt = bip_prev;
                OH_TRACE: nxt = trace;
                OH_MAINT: nxt = {far_fail, febe_pend | blk_err, 3'b000, ptype};
                OH_NETOP: nxt = netop;
                OH_GCC:   nxt = gcc;
                default:  nxt = IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos       <= '0;
            byte_out  <= '0;
            sof       <= 1'b0;
            acc       <= '0;
            bip_prev  <= '0;
            febe_pend <= 1'b0;
        end else begin
            pos      <= last ? '0 : pos + 1'b1;
            byte_out <= nxt;
            sof      <= (pos == '0);
            acc      <= (pos == '0) ? nxt : (acc ^ nxt);
            if (last) bip_prev <= acc ^ nxt;
            if (!slot_req && oh == OH_MAINT) febe_pend <= 1'b0;
            else if (blk_err)                febe_pend <= 1'b1;
        end
    end

    // R1: frame marker coincides with first alignment byte
    p_sof_fa1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> byte_out == FA1);
    // R3: requested slot number stays inside the payload
    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |-> int'(slot_num) < PAY_LEN);
    // R3: offered byte is sent in the next cycle
    p_slot_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req && slot_valid |=> byte_out == $past(slot_data));
    // R4: missing byte becomes idle
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req && !slot_valid |=> byte_out == IDLE);
endmodule

// File: rtl/sframe_rx.sv
module sframe_rx
    import sframe_pkg::*;
#(
    parameter int         PAY_LEN       = 530,
    parameter logic [7:0] FA1           = 8'hF6,
    parameter logic [7:0] FA2           = 8'h28,
    parameter int         LOCK_HITS     = 3,
    parameter int         UNLOCK_MISSES = 4,
    parameter int         ERR_W         = 16,
    localparam int FRAME_LEN = NUM_OH + PAY_LEN,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int SLOT_W    = $clog2(PAY_LEN),
    localparam int HIT_W     = $clog2(LOCK_HITS + 1),
    localparam int MISS_W    = $clog2(UNLOCK_MISSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_byte,
    output logic              lock,
    output logic              pay_valid,
    output logic [SLOT_W-1:0] pay_slot,
    output logic [7:0]        pay_data,
    output logic [ERR_W-1:0]  err_cnt,
    output logic              err_pulse
);
    rx_state_t         state, nstate;
    logic [POS_W-1:0]  rpos;
    logic [7:0]        prev;
    logic [7:0]        acc;
    logic [7:0]        calc;
    logic [HIT_W-1:0]  hits;
    logic [MISS_W-1:0] misses;
    logic              align_ok;
    logic              at_fa2;
    logic              chk_bad;

    assign align_ok = (prev == FA1) && (in_byte == FA2);
    assign at_fa2   = (rpos == POS_W'(1));
    assign chk_bad  = (state == RX_LOCKED) && (rpos == POS_W'(2)) && (in_byte != calc);
    assign lock     = (state == RX_LOCKED);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            RX_HUNT:
                if (align_ok) nstate = RX_CONFIRM;
            RX_CONFIRM:
                if (at_fa2) begin
                    if (!align_ok)                          nstate = RX_HUNT;
                    else if (hits == HIT_W'(LOCK_HITS - 1)) nstate = RX_LOCKED;
                end
            RX_LOCKED:
                if (at_fa2 && !align_ok && misses == MISS_W'(UNLOCK_MISSES - 1))
                    nstate = RX_HUNT;
            default: nstate = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpos      <= '0;
            prev      <= '0;
            acc       <= '0;
            calc      <= '0;
            hits      <= '0;
            misses    <= '0;
            pay_valid <= 1'b0;
            pay_slot  <= '0;
            pay_data  <= '0;
            err_cnt   <= '0;
            err_pulse <= 1'b0;
        end else begin
            prev <= in_byte;
            if (state == RX_HUNT) begin
                rpos   <= POS_W'(2);
                acc    <= prev ^ in_byte;
                hits   <= HIT_W'(1);
                misses <= '0;
            end else begin
                rpos <= (rpos == POS_W'(FRAME_LEN - 1)) ? '0 : rpos + 1'b1;
                acc  <= (rpos == '0) ? in_byte : (acc ^ in_byte);
                if (rpos == POS_W'(FRAME_LEN - 1)) calc <= acc ^ in_byte;
                if (at_fa2 && align_ok && state == RX_CONFIRM) hits <= hits + 1'b1;
                if (at_fa2 && state == RX_LOCKED)
                    misses <= align_ok ? '0 : misses + 1'b1;
            end
            pay_valid <= lock && (rpos >= POS_W'(NUM_OH));
            pay_slot  <= SLOT_W'(rpos - POS_W'(NUM_OH));
            pay_data  <= in_byte;
            err_pulse <= chk_bad;
            if (chk_bad && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
        end
    end

    // R7: lock is entered only from the confirm state
    p_lock_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_LOCKED) && ($past(state) != RX_LOCKED) |-> $past(state) == RX_CONFIRM);
    // R9: payload only presented while locked
    p_pay_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> lock);
    // R9: the last slot ends a frame's payload
    p_pay_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid && int'(pay_slot) == PAY_LEN - 1 |=> !pay_valid);
    // R10: counter steps by one only
    p_err_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt != $past(err_cnt) |-> err_cnt == $past(err_cnt) + 1'b1);
    // R10: counter holds at saturation
    p_err_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt == '1 |=> err_cnt == '1);
endmodule

// File: rtl/sframe_top.sv
module sframe_top #(
    parameter int         PAY_LEN       = 530,
    parameter logic [7:0] FA1           = 8'hF6,
    parameter logic [7:0] FA2           = 8'h28,
    parameter logic [7:0] IDLE          = 8'hFF,
    parameter int         LOCK_HITS     = 3,
    parameter int         UNLOCK_MISSES = 4,
    parameter int         ERR_W         = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 tx_trace,
    input  logic [7:0]                 tx_netop,
    input  logic [7:0]                 tx_gcc,
    input  logic [2:0]                 tx_ptype,
    output logic                       tx_slot_req,
    output logic [$clog2(PAY_LEN)-1:0] tx_slot_num,
    input  logic                       tx_slot_valid,
    input  logic [7:0]                 tx_slot_data,
    output logic [7:0]                 tx_byte,
    output logic                       tx_sof,
    input  logic [7:0]                 rx_byte,
    output logic                       rx_lock,
    output logic                       rx_pay_valid,
    output logic [$clog2(PAY_LEN)-1:0] rx_pay_slot,
    output logic [7:0]                 rx_pay_data,
    output logic [ERR_W-1:0]           rx_bip_errs
);
    logic bip_err;

    sframe_tx #(
        .PAY_LEN(PAY_LEN), .FA1(FA1), .FA2(FA2), .IDLE(IDLE)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .trace(tx_trace), .netop(tx_netop), .gcc(tx_gcc), .ptype(tx_ptype),
        .far_fail(!rx_lock), .blk_err(bip_err),
        .slot_req(tx_slot_req), .slot_num(tx_slot_num),
        .slot_valid(tx_slot_valid), .slot_data(tx_slot_data),
        .byte_out(tx_byte), .sof(tx_sof)
    );

    sframe_rx #(
        .PAY_LEN(PAY_LEN), .FA1(FA1), .FA2(FA2),
        .LOCK_HITS(LOCK_HITS), .UNLOCK_MISSES(UNLOCK_MISSES), .ERR_W(ERR_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .in_byte(rx_byte),
        .lock(rx_lock), .pay_valid(rx_pay_valid), .pay_slot(rx_pay_slot),
        .pay_data(rx_pay_data), .err_cnt(rx_bip_errs), .err_pulse(bip_err)
    );
endmodule

// File: tb/sim_sframe_top.sv
`timescale 1ns/1ps
module sim_sframe_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_slot_req, tx_slot_valid, tx_sof, rx_lock, rx_pay_valid;
    logic [9:0]  tx_slot_num, rx_pay_slot;
    logic [7:0]  tx_slot_data, tx_byte, rx_byte, rx_pay_data;
    logic [15:0] rx_bip_errs;
    logic [7:0]  cmask = 8'h00;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    assign tx_slot_valid = (int'(tx_slot_num) % 5) != 3;
    assign tx_slot_data  = tx_slot_num[7:0] ^ 8'h5A;
    assign rx_byte       = tx_byte ^ cmask;

    sframe_top u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_trace(8'hA1), .tx_netop(8'hB2), .tx_gcc(8'hC3), .tx_ptype(3'd5),
        .tx_slot_req(tx_slot_req), .tx_slot_num(tx_slot_num),
        .tx_slot_valid(tx_slot_valid), .tx_slot_data(tx_slot_data),
        .tx_byte(tx_byte), .tx_sof(tx_sof), .rx_byte(rx_byte),
        .rx_lock(rx_lock), .rx_pay_valid(rx_pay_valid), .rx_pay_slot(rx_pay_slot),
        .rx_pay_data(rx_pay_data), .rx_bip_errs(rx_bip_errs)
    );

    localparam int         NTAB = 8;
    localparam int         TAB_SLOT [NTAB] = '{0, 1, 3, 8, 172, 255, 256, 529};
    localparam logic [7:0] TAB_EXP  [NTAB] = '{8'h5A, 8'h5B, 8'hFF, 8'hFF,
                                               8'hF6, 8'hA5, 8'h5A, 8'h4B};

    function automatic logic [7:0] slot_exp(int s);
        return (s % 5 == 3) ? 8'hFF : (8'(s) ^ 8'h5A);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [7:0] fr   [537];
    logic [7:0] last [537];
    int   bpos = 0;
    bit   started = 0;
    int   nframes = 0;
    int   len_bad = 0;
    int   corr_idx = 0;
    int   corr_left = 0;
    bit   rx_chk_en = 1;
    int   rx_bad = 0;
    int   rx_frames = 0;
    int   rx_next = -1;
    event fdone;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_sof) begin
                if (started && bpos != 536) len_bad++;
                bpos = 0;
                started = 1;
            end else if (started) begin
                bpos++;
                if (bpos > 536) len_bad++;
            end
            if (started && bpos <= 536) begin
                fr[bpos] = tx_byte;
                cmask = (corr_left > 0 && bpos == corr_idx) ? 8'h01 : 8'h00;
                if (bpos == 536) begin
                    if (corr_left > 0) corr_left--;
                    for (int i = 0; i < 537; i++) last[i] = fr[i];
                    nframes++;
                    -> fdone;
                end
            end
            if (rx_pay_valid && rx_chk_en) begin
                if (rx_next >= 0 && int'(rx_pay_slot) != rx_next) rx_bad++;
                if (rx_pay_data != slot_exp(int'(rx_pay_slot))) rx_bad++;
                if (int'(rx_pay_slot) == 529) begin
                    rx_frames++;
                    rx_next = 0;
                end else begin
                    rx_next = int'(rx_pay_slot) + 1;
                end
            end
        end
    end

    task automatic wait_frame(input int n);
        while (nframes < n) @(fdone);
    endtask

    function automatic logic [7:0] xor_last();
        logic [7:0] x = 8'h00;
        for (int i = 0; i < 537; i++) x ^= last[i];
        return x;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] px;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(tx_sof == 0 && rx_lock == 0 && rx_pay_valid == 0, "R12 reset outputs",
            {tx_sof, rx_lock, rx_pay_valid}, 0);
        chk(rx_bip_errs == 0, "R12 reset counter", rx_bip_errs, 0);
        rst_n = 1'b1;

        wait_frame(1);
        chk(last[0] == 8'hF6 && last[1] == 8'h28, "R1 alignment bytes",
            {last[0], last[1]}, 16'hF628);
        chk(last[2] == 8'h00, "R5 first parity byte", last[2], 0);
        chk(last[3] == 8'hA1 && last[5] == 8'hB2 && last[6] == 8'hC3, "R2 overhead bytes",
            {last[3], last[5], last[6]}, 24'hA1B2C3);
        chk(last[4] == 8'h85, "R6 maintenance unlocked", last[4], 8'h85);
        chk(rx_lock == 0, "R7 no lock after one frame", rx_lock, 0);
        for (int i = 0; i < NTAB; i++)
            chk(last[7 + TAB_SLOT[i]] == TAB_EXP[i], "R3 R4 slot byte",
                last[7 + TAB_SLOT[i]], TAB_EXP[i]);
        px = xor_last();

        wait_frame(2);
        chk(last[2] == px, "R5 parity of previous frame", last[2], px);
        chk(rx_lock == 0, "R7 no lock after two frames", rx_lock, 0);
        for (int i = 0; i < 5; i++)
            chk(last[7 + i] == slot_exp(i), "R3 slot restarts", last[7 + i], slot_exp(i));

        wait_frame(3);
        chk(rx_lock == 1, "R7 lock after three frames", rx_lock, 1);
        px = xor_last();

        wait_frame(4);
        chk(last[4] == 8'h05, "R6 maintenance locked", last[4], 8'h05);
        chk(last[2] == px, "R5 parity frame 4", last[2], px);

        wait_frame(5);
        chk(rx_frames >= 1 && rx_bad == 0, "R9 payload slots and data", rx_bad, 0);
        chk(rx_bip_errs == 0, "R10 no errors clean link", rx_bip_errs, 0);
        rx_chk_en = 0;
        corr_idx = 100;
        corr_left = 1;

        wait_frame(7);
        chk(rx_bip_errs == 1, "R10 mismatch counted", rx_bip_errs, 1);
        chk(last[4] == 8'h45, "R11 block error flagged", last[4], 8'h45);

        wait_frame(8);
        chk(last[4] == 8'h05, "R11 flag only once", last[4], 8'h05);
        chk(rx_bip_errs == 1 && rx_lock == 1, "R10 count stable", rx_bip_errs, 1);
        corr_idx = 1;
        corr_left = 3;

        wait_frame(11);
        chk(rx_lock == 1, "R8 held through three misses", rx_lock, 1);
        corr_left = 1;

        wait_frame(12);
        chk(rx_lock == 0, "R8 lost on fourth miss", rx_lock, 0);
        chk(last[4] == 8'h85, "R6 receive fail after loss", last[4], 8'h85);
        chk(rx_bip_errs == 3, "R10 only counted in lock", rx_bip_errs, 3);

        wait_frame(14);
        chk(rx_lock == 0, "R7 relock not early", rx_lock, 0);

        wait_frame(15);
        chk(rx_lock == 1, "R7 relock after three frames", rx_lock, 1);
        chk(len_bad == 0, "R1 frame length 537", len_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule